// File: doc/BRIEF.md
# Asynchronous Enable-Strobe LCD Bus Sequencer

This block carries out single accesses on an asynchronous parallel LCD bus of the register-select, read/write and enable kind. A host raises a request with an operation code: write a command, write data, read status or read data. The block then runs the access through a setup phase, an enable-strobe phase and a hold phase, then an optional quiet gap before the next access. Every phase length is counted in cycles of the block's clock. Reads and writes have separate setup, strobe and hold lengths. The gap length is shared.

The enable strobe is steered to one of two enable pins, so two panel controllers can sit on one bus. The clock itself never reaches the panel. On writes the block drives the latched data word. On reads it releases the bus and samples it on the last strobe cycle. It returns the sampled word with a one-cycle done pulse. A request made while the block is busy waits until the current access, including its gap, has completed.

Top module: `lcd_async_bus_seq`

## Requirements
- R1: When `busy_o` is low and `req_i` is high at a clock edge, an access starts. `busy_o` is high for exactly S+W+H+C cycles after that edge, then low for at least one cycle. S, W, H and C are the setup, strobe, hold and gap lengths that were in force when the access started.
- R2: `op_i[0]` drives `lcd_rs_o` (1 = data, 0 = command/status). `op_i[1]` drives `lcd_rw_o` (1 = read, 0 = write). Both are held constant from the first setup cycle to the last hold cycle. Outside that span `lcd_rs_o` is 0 and `lcd_rw_o` is 1.
- R3: The setup phase lasts S cycles. S comes from `rd_setup_i` when `op_i[1]` is 1 and from `wr_setup_i` when it is 0. If S is 0, the enable is high in the first cycle of the access.
- R4: The enable is high for W consecutive cycles immediately after setup, and never outside that span. W is the selected strobe length (`rd_strobe_i` or `wr_strobe_i`), and a value of 0 counts as 1.
- R5: The hold phase follows the strobe for H cycles. H is the selected hold length (`rd_hold_i` or `wr_hold_i`), and a value of 0 counts as 1.
- R6: After hold, `busy_o` stays high for C = `cs_delay_i` cycles. During these cycles the enables and the data drive are off, and RS and R/W are at their idle levels.
- R7: When `en_sel_i` is 0 the strobe goes out on `lcd_en_o[0]`; when it is 1 it goes out on `lcd_en_o[1]`. At most one enable is ever high.
- R8: On writes, `lcd_data_oe_o` is 1 and `lcd_data_o` carries the write word from the first setup cycle to the last hold cycle. At all other times `lcd_data_oe_o` is 0 and `lcd_data_o` is 0.
- R9: On reads, `lcd_data_i` is sampled at the clock edge that ends the last strobe cycle and appears on `rdata_o`. `rdata_o` keeps that value until the next read samples; writes leave it unchanged.
- R10: `done_o` is high for exactly one cycle: the first cycle after the last hold cycle.
- R11: A request held high while `busy_o` is high has no effect on the running access. It is accepted at the first edge at which `busy_o` is low.
- R12: The operation, write word, enable select and timing inputs are captured when the access starts. Changing them during the access has no effect on it.
- R13: While `rst_ni` is low: `busy_o` and `done_o` are 0, the enables and data drive are off, `lcd_rs_o` is 0, `lcd_rw_o` is 1 and `rdata_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sequencing clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request, level |
| op_i | input | 2 | Bit 0: RS level, bit 1: read |
| wdata_i | input | DATA_W | Write word |
| en_sel_i | input | EN_SEL_W | Enable pin select |
| rd_setup_i | input | SETUP_W | Read setup length |
| rd_strobe_i | input | STROBE_W | Read strobe length |
| rd_hold_i | input | HOLD_W | Read hold length |
| wr_setup_i | input | SETUP_W | Write setup length |
| wr_strobe_i | input | STROBE_W | Write strobe length |
| wr_hold_i | input | HOLD_W | Write hold length |
| cs_delay_i | input | CSD_W | Gap after hold |
| busy_o | output | 1 | Access in progress |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | DATA_W | Last read word |
| lcd_rs_o | output | 1 | Register select to panel |
| lcd_rw_o | output | 1 | Read/write to panel (1 = read) |
| lcd_en_o | output | N_EN | Enable strobes |
| lcd_data_o | output | DATA_W | Bus data out |
| lcd_data_oe_o | output | 1 | Bus output enable |
| lcd_data_i | input | DATA_W | Bus data in |

## Verification
The bench builds the block with its default widths: a 16-bit bus, two enables, and 5/6/4/2-bit setup, strobe, hold and gap fields. It sweeps setup 0 to 3, strobe 0 to 3, hold 0 to 2 and gaps of 0, 1 and 3 across all four operations and both enables. This reaches the zero-setup path, the zero-to-one clamping of strobe and hold, and the gap-free return to idle. In every iteration the unused direction's timing set is loaded with different values, so a swap of the read and write sets shows up in the timing. The bus input changes every cycle, so the sample point is fixed to one cycle. After each start the bench scrambles all request inputs, and it holds the request high through some accesses, which exercises input capture and the hold-off path.

// File: rtl/lcd_seq_pkg.sv
package lcd_seq_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SETUP,
    PH_STROBE,
    PH_HOLD,
    PH_CSD
  } phase_e;

  function automatic int unsigned max2(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/lcd_phase_timer.sv
module lcd_phase_timer #(
  parameter int unsigned CNT_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             last_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (load_i)       cnt_q <= len_i;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign last_o = (cnt_q == CNT_W'(1));

  // R1: an expired counter stays expired until reloaded
  a_r1_cnt_no_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && cnt_q == '0) |=> (cnt_q == '0));

endmodule

// File: rtl/lcd_timing_sel.sv
module lcd_timing_sel #(
  parameter int unsigned SETUP_W  = 5,
  parameter int unsigned STROBE_W = 6,
  parameter int unsigned HOLD_W   = 4,
  parameter int unsigned CSD_W    = 2,
  parameter int unsigned CNT_W    = 6
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                idle_i,
  input  logic                accept_i,
  input  logic                is_read_i,
  input  logic [SETUP_W-1:0]  rd_setup_i,
  input  logic [STROBE_W-1:0] rd_strobe_i,
  input  logic [HOLD_W-1:0]   rd_hold_i,
  input  logic [SETUP_W-1:0]  wr_setup_i,
  input  logic [STROBE_W-1:0] wr_strobe_i,
  input  logic [HOLD_W-1:0]   wr_hold_i,
  input  logic [CSD_W-1:0]    cs_delay_i,
  output logic [CNT_W-1:0]    setup_len_o,
  output logic [CNT_W-1:0]    strobe_len_o,
  output logic [CNT_W-1:0]    hold_len_o,
  output logic [CNT_W-1:0]    csd_len_o
);

  logic [STROBE_W-1:0] st_raw;
  logic [HOLD_W-1:0]   hd_raw;
  logic [CNT_W-1:0]    su_live, st_live, hd_live, cd_live;
  logic [CNT_W-1:0]    su_q, st_q, hd_q, cd_q;

  assign st_raw  = is_read_i ? rd_strobe_i : wr_strobe_i;
  assign hd_raw  = is_read_i ? rd_hold_i   : wr_hold_i;
  assign su_live = CNT_W'(is_read_i ? rd_setup_i : wr_setup_i);
  // zero strobe/hold are illegal: run them as one cycle
  assign st_live = (st_raw == '0) ? CNT_W'(1) : CNT_W'(st_raw);
  assign hd_live = (hd_raw == '0) ? CNT_W'(1) : CNT_W'(hd_raw);
  assign cd_live = CNT_W'(cs_delay_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      su_q <= '0;
      st_q <= CNT_W'(1);
      hd_q <= CNT_W'(1);
      cd_q <= '0;
    end else if (accept_i) begin
      su_q <= su_live;
      st_q <= st_live;
      hd_q <= hd_live;
      cd_q <= cd_live;
    end
  end

  assign setup_len_o  = idle_i ? su_live : su_q;
  assign strobe_len_o = idle_i ? st_live : st_q;
  assign hold_len_o   = idle_i ? hd_live : hd_q;
  assign csd_len_o    = idle_i ? cd_live : cd_q;

endmodule

// File: rtl/lcd_phase_fsm.sv
module lcd_phase_fsm
  import lcd_seq_pkg::*;
#(
  parameter int unsigned CNT_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             last_i,
  input  logic [CNT_W-1:0] setup_len_i,
  input  logic [CNT_W-1:0] strobe_len_i,
  input  logic [CNT_W-1:0] hold_len_i,
  input  logic [CNT_W-1:0] csd_len_i,
  output phase_e           phase_o,
  output logic             load_o,
  output logic [CNT_W-1:0] load_len_o,
  output logic             accept_o,
  output logic             sample_o,
  output logic             done_o
);

  phase_e phase_q, phase_d;
  logic   done_q;

  always_comb begin
    phase_d    = phase_q;
    load_len_o = '0;
    unique case (phase_q)
      PH_IDLE: if (req_i) begin
        if (setup_len_i != '0) begin
          phase_d = PH_SETUP;  load_len_o = setup_len_i;
        end else begin
          phase_d = PH_STROBE; load_len_o = strobe_len_i;
        end
      end
      PH_SETUP: if (last_i) begin
        phase_d = PH_STROBE; load_len_o = strobe_len_i;
      end
      PH_STROBE: if (last_i) begin
        phase_d = PH_HOLD; load_len_o = hold_len_i;
      end
      PH_HOLD: if (last_i) begin
        if (csd_len_i != '0) begin
          phase_d = PH_CSD; load_len_o = csd_len_i;
        end else begin
          phase_d = PH_IDLE;
        end
      end
      PH_CSD: if (last_i) phase_d = PH_IDLE;
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      done_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      done_q  <= (phase_q == PH_HOLD) && last_i;
    end
  end

  assign phase_o  = phase_q;
  assign load_o   = (phase_d != phase_q);
  assign accept_o = (phase_q == PH_IDLE) && req_i;
  assign sample_o = (phase_q == PH_STROBE) && last_i;
  assign done_o   = done_q;

  a_r10_done_after_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_HOLD && last_i) |=> done_o);
  a_r4_strobe_then_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_STROBE && last_i) |=> (phase_q == PH_HOLD));
  a_r11_no_early_exit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q != PH_IDLE && !last_i) |=> $stable(phase_q));
  a_r1_idle_timer_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_IDLE) |-> !last_i);

endmodule

// File: rtl/lcd_pin_drv.sv
module lcd_pin_drv
  import lcd_seq_pkg::*;
#(
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned N_EN     = 2,
  parameter int unsigned EN_SEL_W = 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                accept_i,
  input  logic [1:0]          op_i,
  input  logic [DATA_W-1:0]   wdata_i,
  input  logic [EN_SEL_W-1:0] en_sel_i,
  input  phase_e              phase_i,
  input  logic                sample_i,
  input  logic [DATA_W-1:0]   lcd_data_i,
  output logic                lcd_rs_o,
  output logic                lcd_rw_o,
  output logic [N_EN-1:0]     lcd_en_o,
  output logic [DATA_W-1:0]   lcd_data_o,
  output logic                lcd_data_oe_o,
  output logic [DATA_W-1:0]   rdata_o
);

  logic                rs_q, rw_q;
  logic [DATA_W-1:0]   wd_q, rd_q;
  logic [EN_SEL_W-1:0] sel_q;
  logic                active, strobe;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rs_q  <= 1'b0;
      rw_q  <= 1'b1;
      wd_q  <= '0;
      sel_q <= '0;
    end else if (accept_i) begin
      rs_q  <= op_i[0];
      rw_q  <= op_i[1];
      wd_q  <= wdata_i;
      sel_q <= en_sel_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                rd_q <= '0;
    else if (sample_i && rw_q)  rd_q <= lcd_data_i;
  end

  assign active = (phase_i == PH_SETUP) || (phase_i == PH_STROBE) || (phase_i == PH_HOLD);
  assign strobe = (phase_i == PH_STROBE);

  assign lcd_rs_o      = active ? rs_q : 1'b0;
  assign lcd_rw_o      = active ? rw_q : 1'b1;
  assign lcd_data_oe_o = active && !rw_q;
  assign lcd_data_o    = lcd_data_oe_o ? wd_q : '0;
  assign rdata_o       = rd_q;

  for (genvar i = 0; i < N_EN; i++) begin : g_en
    assign lcd_en_o[i] = strobe && (sel_q == EN_SEL_W'(i));
  end

  a_r7_one_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(lcd_en_o));
  a_r2_rs_rw_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active && $past(active)) |-> ($stable(lcd_rs_o) && $stable(lcd_rw_o)));
  a_r8_drive_on_write_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lcd_data_oe_o |-> !lcd_rw_o);
  a_r4_enable_inside_access: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|lcd_en_o) |-> (phase_i != PH_IDLE && phase_i != PH_CSD));

endmodule

// File: rtl/lcd_async_bus_seq.sv
module lcd_async_bus_seq
  import lcd_seq_pkg::*;
#(
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned N_EN     = 2,
  parameter int unsigned SETUP_W  = 5,
  parameter int unsigned STROBE_W = 6,
  parameter int unsigned HOLD_W   = 4,
  parameter int unsigned CSD_W    = 2,
  localparam int unsigned EN_SEL_W = (N_EN > 1) ? $clog2(N_EN) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_i,
  input  logic [1:0]          op_i,
  input  logic [DATA_W-1:0]   wdata_i,
  input  logic [EN_SEL_W-1:0] en_sel_i,
  input  logic [SETUP_W-1:0]  rd_setup_i,
  input  logic [STROBE_W-1:0] rd_strobe_i,
  input  logic [HOLD_W-1:0]   rd_hold_i,
  input  logic [SETUP_W-1:0]  wr_setup_i,
  input  logic [STROBE_W-1:0] wr_strobe_i,
  input  logic [HOLD_W-1:0]   wr_hold_i,
  input  logic [CSD_W-1:0]    cs_delay_i,
  output logic                busy_o,
  output logic                done_o,
  output logic [DATA_W-1:0]   rdata_o,
  output logic                lcd_rs_o,
  output logic                lcd_rw_o,
  output logic [N_EN-1:0]     lcd_en_o,
  output logic [DATA_W-1:0]   lcd_data_o,
  output logic                lcd_data_oe_o,
  input  logic [DATA_W-1:0]   lcd_data_i
);

  localparam int unsigned CNT_W = max2(max2(SETUP_W, STROBE_W), max2(HOLD_W, CSD_W));

  phase_e           phase;
  logic             accept, sample, last, load;
  logic [CNT_W-1:0] load_len, su_len, st_len, hd_len, cd_len;

  lcd_timing_sel #(
    .SETUP_W (SETUP_W), .STROBE_W(STROBE_W), .HOLD_W(HOLD_W),
    .CSD_W   (CSD_W),   .CNT_W   (CNT_W)
  ) u_tsel (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .idle_i      (phase == PH_IDLE),
    .accept_i    (accept),
    .is_read_i   (op_i[1]),
    .rd_setup_i  (rd_setup_i),
    .rd_strobe_i (rd_strobe_i),
    .rd_hold_i   (rd_hold_i),
    .wr_setup_i  (wr_setup_i),
    .wr_strobe_i (wr_strobe_i),
    .wr_hold_i   (wr_hold_i),
    .cs_delay_i  (cs_delay_i),
    .setup_len_o (su_len),
    .strobe_len_o(st_len),
    .hold_len_o  (hd_len),
    .csd_len_o   (cd_len)
  );

  lcd_phase_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_i       (req_i),
    .last_i      (last),
    .setup_len_i (su_len),
    .strobe_len_i(st_len),
    .hold_len_i  (hd_len),
    .csd_len_i   (cd_len),
    .phase_o     (phase),
    .load_o      (load),
    .load_len_o  (load_len),
    .accept_o    (accept),
    .sample_o    (sample),
    .done_o      (done_o)
  );

  lcd_phase_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(load),
    .len_i (load_len),
    .last_o(last)
  );

  lcd_pin_drv #(.DATA_W(DATA_W), .N_EN(N_EN), .EN_SEL_W(EN_SEL_W)) u_pins (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .accept_i     (accept),
    .op_i         (op_i),
    .wdata_i      (wdata_i),
    .en_sel_i     (en_sel_i),
    .phase_i      (phase),
    .sample_i     (sample),
    .lcd_data_i   (lcd_data_i),
    .lcd_rs_o     (lcd_rs_o),
    .lcd_rw_o     (lcd_rw_o),
    .lcd_en_o     (lcd_en_o),
    .lcd_data_o   (lcd_data_o),
    .lcd_data_oe_o(lcd_data_oe_o),
    .rdata_o      (rdata_o)
  );

  assign busy_o = (phase != PH_IDLE);

  // R6: no pin activity while only the gap remains
  a_r6_quiet_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase == PH_CSD) |-> (lcd_en_o == '0 && !lcd_data_oe_o && lcd_rw_o && !lcd_rs_o));
  a_r10_done_when_free: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (lcd_en_o == '0 && !lcd_data_oe_o));

endmodule

// File: tb/sim_lcd_async_bus_seq.sv
module sim_lcd_async_bus_seq;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0;
  logic [1:0]  op_i = '0;
  logic [15:0] wdata_i = '0;
  logic [0:0]  en_sel_i = '0;
  logic [4:0]  rd_setup_i = '0, wr_setup_i = '0;
  logic [5:0]  rd_strobe_i = '0, wr_strobe_i = '0;
  logic [3:0]  rd_hold_i = '0, wr_hold_i = '0;
  logic [1:0]  cs_delay_i = '0;
  logic        busy_o, done_o, lcd_rs_o, lcd_rw_o, lcd_data_oe_o;
  logic [15:0] rdata_o, lcd_data_o;
  logic [15:0] lcd_data_i = '0;
  logic [1:0]  lcd_en_o;

  int n_checks = 0;
  int n_errors = 0;
  logic [15:0] last_rd = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lcd_async_bus_seq u0 (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req_i), .op_i(op_i), .wdata_i(wdata_i),
    .en_sel_i(en_sel_i), .rd_setup_i(rd_setup_i), .rd_strobe_i(rd_strobe_i),
    .rd_hold_i(rd_hold_i), .wr_setup_i(wr_setup_i), .wr_strobe_i(wr_strobe_i),
    .wr_hold_i(wr_hold_i), .cs_delay_i(cs_delay_i), .busy_o(busy_o), .done_o(done_o),
    .rdata_o(rdata_o), .lcd_rs_o(lcd_rs_o), .lcd_rw_o(lcd_rw_o), .lcd_en_o(lcd_en_o),
    .lcd_data_o(lcd_data_o), .lcd_data_oe_o(lcd_data_oe_o), .lcd_data_i(lcd_data_i)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] pat(input int k);
    return 16'h3C00 ^ 16'(k * 37);
  endfunction

  // one access; inputs set now, accepted at the next rising edge
  task automatic run_access(input int op, input int sel, input int s, input int w,
                            input int h, input int c, input bit keep_req);
    logic [15:0] wd;
    int ww, hh, t, k_st0, k_st1, k_act;
    bit is_rd;
    is_rd = (op >= 2);
    wd = 16'hC000 ^ 16'((s << 10) | (w << 6) | (h << 2) | c) ^ 16'(op << 8) ^ 16'(sel << 13);
    op_i = 2'(op); en_sel_i = 1'(sel); wdata_i = wd; cs_delay_i = 2'(c);
    if (is_rd) begin
      rd_setup_i = 5'(s); rd_strobe_i = 6'(w); rd_hold_i = 4'(h);
      wr_setup_i = 5'(s + 5); wr_strobe_i = 6'(w + 4); wr_hold_i = 4'(h + 3);
    end else begin
      wr_setup_i = 5'(s); wr_strobe_i = 6'(w); wr_hold_i = 4'(h);
      rd_setup_i = 5'(s + 5); rd_strobe_i = 6'(w + 4); rd_hold_i = 4'(h + 3);
    end
    req_i = 1'b1;
    @(posedge clk);
    ww = (w == 0) ? 1 : w;
    hh = (h == 0) ? 1 : h;
    k_st0 = s + 1;
    k_st1 = s + ww;
    k_act = s + ww + hh;
    t = k_act + c;
    for (int k = 1; k <= t + 1; k++) begin
      bit in_st, act;
      string en_tag;
      @(negedge clk);
      lcd_data_i = pat(k);
      if (k == 1) begin
        // R12: scramble every request input after the start
        op_i = ~op_i; wdata_i = ~wdata_i; en_sel_i = ~en_sel_i; cs_delay_i = 2'd3;
        rd_setup_i = '0; rd_strobe_i = 6'd9; rd_hold_i = 4'd7;
        wr_setup_i = '0; wr_strobe_i = 6'd9; wr_hold_i = 4'd7;
        if (!keep_req) req_i = 1'b0;
      end
      in_st = (k >= k_st0) && (k <= k_st1);
      act   = (k <= k_act);
      if (k <= s)          en_tag = "R3 setup";
      else if (in_st)      en_tag = "R4 strobe";
      else if (k <= k_act) en_tag = "R5 hold";
      else if (k <= t)     en_tag = "R6 gap";
      else                 en_tag = "R1 idle";
      check(keep_req ? "R11 busy" : "R1 busy", 32'(busy_o), 32'(k <= t));
      check(en_tag, 32'(lcd_en_o), in_st ? 32'(1 << sel) : 32'd0);
      if (in_st) check("R7 enable select", 32'(lcd_en_o[sel]), 32'd1);
      check("R2 rs", 32'(lcd_rs_o), act ? 32'(op & 1) : 32'd0);
      check("R2 rw", 32'(lcd_rw_o), act ? 32'(op >> 1) : 32'd1);
      check(k == 1 ? "R8 oe" : "R12 oe", 32'(lcd_data_oe_o), 32'(act && !is_rd));
      check(k == 1 ? "R8 data" : "R12 data", 32'(lcd_data_o), (act && !is_rd) ? 32'(wd) : 32'd0);
      check("R10 done", 32'(done_o), 32'(k == k_act + 1));
    end
    if (is_rd) last_rd = pat(k_st1);
    check("R9 rdata", 32'(rdata_o), 32'(last_rd));
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R13 reset state
    check("R13 busy", 32'(busy_o), 0);
    check("R13 done", 32'(done_o), 0);
    check("R13 en", 32'(lcd_en_o), 0);
    check("R13 oe", 32'(lcd_data_oe_o), 0);
    check("R13 rs", 32'(lcd_rs_o), 0);
    check("R13 rw", 32'(lcd_rw_o), 1);
    check("R13 rdata", 32'(rdata_o), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    check("R13 idle after release", 32'(busy_o), 0);
    for (int op = 0; op < 4; op++)
      for (int sel = 0; sel < 2; sel++)
        for (int s = 0; s < 4; s++)
          for (int w = 0; w < 4; w++)
            for (int h = 0; h < 3; h++)
              for (int ci = 0; ci < 3; ci++) begin
                int c;
                c = (ci == 2) ? 3 : ci;
                run_access(op, sel, s, w, h, c, ((s + w + ci) % 3) == 1);
              end
    req_i = 1'b0;
    @(negedge clk);
    check("R1 idle at end", 32'(busy_o), 0);
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule